// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs the external read and write cycles of an 8-bit CPU. The CPU raises a request with an address, a direction flag and write data. The controller latches these values, drives the external address and strobes, and returns a one-clock completion pulse. For a read, the captured data is returned with that pulse. An access with no added delay takes two clocks: an address phase and a data phase.

Two configuration inputs set the timing. Out of reset, one automatic wait clock is added, so every access lasts at least three clocks. A skip input removes that clock. A stretch input makes any access to the top four 16-byte frames of a 256-byte peripheral window last four clocks, whatever the skip input says. An active-low ready line from the bus (`bus_wait_n`) passes through a synchroniser. It is checked in the data phase, and while it reads low the access goes on with no limit, on top of the programmed waits.

Both configuration inputs are sampled when a request is accepted. Requests are taken only while the controller is idle.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: After reset, `cpu_done`, `bus_rd`, `bus_wr` and `bus_doe` are 0. With both configuration inputs at 0, an access lasts 3 clocks, counted from the accepting edge to the edge that raises `cpu_done`.
- R2: With `cfg_skip_auto`=1 and no stretch, an access lasts 2 clocks.
- R3: With `cfg_pf_stretch`=1, an access whose address is between PERIPH_BASE+0xC0 and PERIPH_BASE+0xFF (inclusive) lasts 4 clocks, for either value of `cfg_skip_auto`.
- R4: An address outside that range (for example PERIPH_BASE+0xBF or PERIPH_BASE+0x100), or `cfg_pf_stretch`=0, gives the R1/R2 timing.
- R5: `bus_wait_n` passes through SYNC_STAGES flops and is examined only in the data phase. If it first reads high at edge r after acceptance, the access ends at edge max(programmed length, r+2).
- R6: `cpu_done` is high for exactly one clock. For a read, `cpu_rdata` holds the `bus_din` value sampled at the edge that raises `cpu_done`.
- R7: During a read, `bus_rd` is high for the whole access and `bus_wr` stays low. During a write, `bus_wr` and `bus_doe` are high for the whole access and `bus_dout` carries the write data.
- R8: The configuration inputs are sampled at acceptance. Changes during an access have no effect on that access.
- R9: A request raised while an access is in progress is ignored. No further strobe or `cpu_done` follows it.
- R10: Address, direction and write data are latched at acceptance. `bus_addr` does not follow `cpu_addr` changes during an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken when idle |
| cpu_addr | input | 16 | Access address |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 8 | Write data |
| cfg_skip_auto | input | 1 | 1 removes the automatic wait clock |
| cfg_pf_stretch | input | 1 | 1 stretches the top peripheral frames to 4 clocks |
| cpu_rdata | output | 8 | Read data captured at completion |
| cpu_done | output | 1 | One-clock completion pulse |
| bus_addr | output | 16 | External address |
| bus_din | input | 8 | External read data |
| bus_dout | output | 8 | External write data |
| bus_doe | output | 1 | Write data drive enable |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_wait_n | input | 1 | External extend request, active low |

## Verification
The assertions check these rules on every cycle:
- the completion pulse lasts one clock and comes only out of the data phase;
- a low synchronised wait holds the data phase;
- the latched command and configuration stay stable through an access;
- a stretched peripheral access takes two wait clocks.

The bench scenarios cover the rest:
- the exact latency of each configuration and address-boundary combination;
- the combined effect of programmed waits and a late `bus_wait_n` release;
- that mid-access changes to configuration or address are ignored;
- that a request raised while busy produces no extra bus cycle.

// File: rtl/xbw_pkg.sv
package xbw_pkg;

    parameter int XBW_AW = 16;
    parameter int XBW_DW = 8;
    localparam int XBW_CNT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_DATA = 2'd3
    } xbw_phase_e;

    typedef struct packed {
        logic skip_auto;
        logic pf_stretch;
    } xbw_cfg_t;

    typedef struct packed {
        logic [XBW_AW-1:0] addr;
        logic              wr;
        logic [XBW_DW-1:0] wdata;
    } xbw_cmd_t;

    // Number of programmed wait clocks between the address and data phases.
    function automatic logic [XBW_CNT_W-1:0] xbw_waits(xbw_cfg_t c, logic hit);
        if (c.pf_stretch && hit) return XBW_CNT_W'(2);
        else if (c.skip_auto)    return XBW_CNT_W'(0);
        else                     return XBW_CNT_W'(1);
    endfunction

endpackage

// File: rtl/xbw_sync.sv
module xbw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xbw_region.sv
module xbw_region #(
    parameter int              AW         = 16,
    parameter logic [AW-1:0]   BASE       = 16'h1000,
    parameter int              WIN_BITS   = 8,
    parameter int              FRAME_BITS = 4,
    parameter int              EXT_FRAMES = 4
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam int EXT_LO_I = (1 << WIN_BITS) - EXT_FRAMES * (1 << FRAME_BITS);
    localparam logic [WIN_BITS-1:0] EXT_LO = EXT_LO_I[WIN_BITS-1:0];
    localparam logic [AW-WIN_BITS-1:0] BASE_HI = BASE[AW-1:WIN_BITS];

    logic in_window;
    assign in_window = (addr[AW-1:WIN_BITS] == BASE_HI);
    assign hit       = in_window && (addr[WIN_BITS-1:0] >= EXT_LO);
endmodule

// File: rtl/xbw_seq.sv
module xbw_seq
    import xbw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  xbw_cmd_t             cmd,
    input  xbw_cfg_t             cfg,
    input  logic                 hit,
    input  logic                 wait_ok,
    input  logic [XBW_DW-1:0]    bus_din,
    output logic [XBW_AW-1:0]    bus_addr,
    output logic [XBW_DW-1:0]    bus_dout,
    output logic                 bus_doe,
    output logic                 bus_rd,
    output logic                 bus_wr,
    output logic                 done,
    output logic [XBW_DW-1:0]    rdata
);
    xbw_phase_e           phase;
    xbw_cmd_t             cmd_q;
    xbw_cfg_t             cfg_q;
    logic [XBW_CNT_W-1:0] cnt;
    logic [XBW_CNT_W-1:0] n_waits;
    logic                 done_q;
    logic [XBW_DW-1:0]    rdata_q;
    logic                 active;

    assign n_waits = xbw_waits(cfg_q, hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= ST_IDLE;
            cmd_q   <= '0;
            cfg_q   <= '0;
            cnt     <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                ST_IDLE: begin
                    if (req) begin
                        cmd_q <= cmd;
                        cfg_q <= cfg;
                        phase <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (n_waits == '0) begin
                        phase <= ST_DATA;
                    end else begin
                        cnt   <= n_waits;
                        phase <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cnt == XBW_CNT_W'(1)) phase <= ST_DATA;
                    else                      cnt   <= cnt - XBW_CNT_W'(1);
                end
                ST_DATA: begin
                    if (wait_ok) begin
                        phase  <= ST_IDLE;
                        done_q <= 1'b1;
                        if (!cmd_q.wr) rdata_q <= bus_din;
                    end
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    assign active   = (phase != ST_IDLE);
    assign bus_addr = cmd_q.addr;
    assign bus_dout = cmd_q.wdata;
    assign bus_rd   = active && !cmd_q.wr;
    assign bus_wr   = active &&  cmd_q.wr;
    assign bus_doe  = active &&  cmd_q.wr;
    assign done     = done_q;
    assign rdata    = rdata_q;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R6
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(phase == ST_DATA));

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_DATA && !wait_ok) |=> (phase == ST_DATA && !done_q));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable(cfg_q));

    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable(cmd_q));

    // R3
    stretch_len_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_ADDR && hit && cfg_q.pf_stretch)
            |=> (phase == ST_WAIT) ##1 (phase == ST_WAIT) ##1 (phase == ST_DATA));
endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
    import xbw_pkg::*;
#(
    parameter logic [XBW_AW-1:0] PERIPH_BASE = 16'h1000,
    parameter int                WIN_BITS    = 8,
    parameter int                FRAME_BITS  = 4,
    parameter int                EXT_FRAMES  = 4,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [XBW_AW-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [XBW_DW-1:0] cpu_wdata,
    input  logic              cfg_skip_auto,
    input  logic              cfg_pf_stretch,
    output logic [XBW_DW-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic [XBW_AW-1:0] bus_addr,
    input  logic [XBW_DW-1:0] bus_din,
    output logic [XBW_DW-1:0] bus_dout,
    output logic              bus_doe,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic              bus_wait_n
);
    xbw_cmd_t cmd_in;
    xbw_cfg_t cfg_in;
    logic     hit;
    logic     wait_ok;

    assign cmd_in = '{addr: cpu_addr, wr: cpu_wr, wdata: cpu_wdata};
    assign cfg_in = '{skip_auto: cfg_skip_auto, pf_stretch: cfg_pf_stretch};

    xbw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_wait_n),
        .q   (wait_ok)
    );

    xbw_region #(
        .AW         (XBW_AW),
        .BASE       (PERIPH_BASE),
        .WIN_BITS   (WIN_BITS),
        .FRAME_BITS (FRAME_BITS),
        .EXT_FRAMES (EXT_FRAMES)
    ) u_region (
        .addr (bus_addr),
        .hit  (hit)
    );

    xbw_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (cpu_req),
        .cmd      (cmd_in),
        .cfg      (cfg_in),
        .hit      (hit),
        .wait_ok  (wait_ok),
        .bus_din  (bus_din),
        .bus_addr (bus_addr),
        .bus_dout (bus_dout),
        .bus_doe  (bus_doe),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .done     (cpu_done),
        .rdata    (cpu_rdata)
    );
endmodule

// File: tb/test_xbus_wait_ctrl.sv
module test_xbus_wait_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        cfg_skip_auto = 1'b0;
    logic        cfg_pf_stretch = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        cpu_done;
    logic [15:0] bus_addr;
    logic [7:0]  bus_din;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic        bus_rd;
    logic        bus_wr;
    logic        bus_wait_n = 1'b1;

    always #(CLK_P/2) clk = ~clk;

    xbus_wait_ctrl i_xbus_wait_ctrl (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cfg_skip_auto(cfg_skip_auto),
        .cfg_pf_stretch(cfg_pf_stretch), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wait_n(bus_wait_n)
    );

    // external device model: read data is a function of the address
    assign bus_din = bus_addr[7:0] ^ bus_addr[15:8] ^ 8'hA5;

    typedef struct {
        int          start;
        int          lat;
        bit          wr;
        logic [15:0] addr;
        logic [7:0]  data;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: counts strobes, captures bus values, compares at completion
    int          rd_cnt = 0, wr_cnt = 0;
    logic [15:0] seen_addr = '0;
    logic [7:0]  seen_dout = '0;
    bit          prev_done = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (bus_rd) rd_cnt++;
            if (bus_wr && bus_doe) begin
                wr_cnt++;
                seen_dout = bus_dout;
            end
            if (bus_rd || bus_wr) seen_addr = bus_addr;
            if (cpu_done) begin
                // R6: one-clock pulse
                chk(!prev_done, "R6", "done width", 2, 1);
                if (q.size() == 0) begin
                    // R9: completion with no accepted request
                    chk(0, "R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc - e.start == e.lat, e.tag, "latency", cyc - e.start, e.lat);
                    chk(seen_addr == e.addr, "R10", "bus addr", seen_addr, e.addr);
                    if (e.wr) begin
                        chk(wr_cnt == e.lat && rd_cnt == 0, "R7", "write strobe clocks", wr_cnt, e.lat);
                        chk(seen_dout == e.data, "R7", "write data", seen_dout, e.data);
                    end else begin
                        chk(rd_cnt == e.lat && wr_cnt == 0, "R7", "read strobe clocks", rd_cnt, e.lat);
                        chk(cpu_rdata == e.data, "R6", "read data", cpu_rdata, e.data);
                    end
                end
                rd_cnt = 0;
                wr_cnt = 0;
            end
            prev_done = cpu_done;
        end
    end

    function automatic bit in_ext(input logic [15:0] a);
        return (a[15:8] == 8'h10) && (a[7:0] >= 8'hC0);
    endfunction

    task automatic access(input logic [15:0] a, input bit wr, input logic [7:0] wd,
                          input bit skip, input bit pf, input int rel,
                          input bit mid_chg, input bit ghost, input string tag);
        exp_t e;
        int   base;
        int   start;
        base = (pf && in_ext(a)) ? 4 : (skip ? 2 : 3);
        if (rel > 0) begin
            bus_wait_n = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
        cfg_skip_auto  = skip;
        cfg_pf_stretch = pf;
        cpu_addr  = a;
        cpu_wr    = wr;
        cpu_wdata = wd;
        cpu_req   = 1'b1;
        @(negedge clk);
        start = cyc;
        e.start = start;
        e.lat   = (rel > 0 && rel + 2 > base) ? rel + 2 : base;
        e.wr    = wr;
        e.addr  = a;
        e.data  = wr ? wd : (a[7:0] ^ a[15:8] ^ 8'hA5);
        e.tag   = tag;
        q.push_back(e);
        cpu_req = ghost;
        if (mid_chg) begin
            cfg_skip_auto  = ~skip;
            cfg_pf_stretch = ~pf;
            cpu_addr  = a ^ 16'h0F0F;
            cpu_wdata = ~wd;
        end
        for (int k = 0; k < 64 && q.size() != 0; k++) begin
            if (rel > 0 && cyc == start + rel - 1) bus_wait_n = 1'b1;
            @(negedge clk);
            cpu_req = 1'b0;
        end
        if (q.size() != 0) begin
            chk(0, tag, "no completion", 0, 1);
            q.delete();
        end
        bus_wait_n = 1'b1;
        cpu_req    = 1'b0;
        if (ghost) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                // R9: no new strobe after the ignored request
                chk(!bus_rd && !bus_wr && !cpu_done, "R9", "idle after busy req",
                    int'(bus_rd | bus_wr | cpu_done), 0);
            end
        end
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!cpu_done && !bus_rd && !bus_wr && !bus_doe, "R1", "reset outputs",
            int'({cpu_done, bus_rd, bus_wr, bus_doe}), 0);

        access(16'h0040, 0, 8'h00, 0, 0, 0, 0, 0, "R1");
        access(16'h0041, 1, 8'h3C, 0, 0, 0, 0, 0, "R7");
        access(16'h0042, 0, 8'h00, 1, 0, 0, 0, 0, "R2");
        access(16'h0243, 1, 8'hC3, 1, 0, 0, 0, 0, "R2");
        access(16'h10C0, 0, 8'h00, 0, 1, 0, 0, 0, "R3");
        access(16'h10FF, 0, 8'h00, 1, 1, 0, 0, 0, "R3");
        access(16'h10D5, 1, 8'h99, 0, 1, 0, 0, 0, "R3");
        access(16'h10BF, 0, 8'h00, 0, 1, 0, 0, 0, "R4");
        access(16'h1100, 0, 8'h00, 1, 1, 0, 0, 0, "R4");
        access(16'h10C0, 0, 8'h00, 0, 0, 0, 0, 0, "R4");
        access(16'h0050, 0, 8'h00, 0, 0, 6, 0, 0, "R5");
        access(16'h10E0, 0, 8'h00, 0, 1, 7, 0, 0, "R5");
        access(16'h0051, 0, 8'h00, 0, 0, 1, 0, 0, "R5");
        access(16'h0352, 1, 8'h5E, 1, 0, 4, 0, 0, "R5");
        access(16'h10C4, 0, 8'h00, 0, 1, 0, 1, 0, "R8");
        access(16'h0060, 1, 8'h77, 1, 0, 0, 1, 0, "R8");
        access(16'h0070, 0, 8'h00, 0, 0, 0, 0, 1, "R9");
        access(16'h0071, 0, 8'h00, 1, 0, 0, 0, 0, "R6");
        repeat (3) @(negedge clk);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end
endmodule